// File: doc/BRIEF.md
# LIN Header Serial Transmitter

This block is the transmit half of a byte-oriented asynchronous serial port, extended so that a bus master can put a complete LIN header on the wire. It holds one byte in a holding buffer and a second in a shift engine. It frames each byte as a plain 8N1 character on an idle-high line. On request it sends a long dominant-low break field, followed by a short recessive delimiter.

Software uses it as a master in three steps. It strobes the break request. It writes the synch byte 0x55, which may be queued while the break is still going out. When the buffer-empty flag rises, it writes the identifier byte. The line then carries break, delimiter, synch and identifier with no idle gaps. In slave mode the break request is ignored, so the block behaves as an ordinary character transmitter.

Bit timing comes from an external rate generator. It supplies a one-cycle `baud_tick` per bit period. Every line transition is aligned to a tick.

Top module: `lin_hdr_tx`

## Requirements
- R1: After a synchronous active-low reset, `txd` is high, `buf_empty` is 1, `tx_done` is 1 and no break is pending.
- R2: In master mode (`master_mode`=1), a one-cycle `brk_wr` strobe causes exactly 13 consecutive low bit times on `txd`, each one `baud_tick` period long.
- R3: In slave mode (`master_mode`=0), a `brk_wr` strobe has no effect: `txd` stays high, `tx_done` stays 1 and no break is sent later.
- R4: A break is followed by exactly one high delimiter bit before a queued character's start bit.
- R5: Each character is one low start bit, then 8 data bits LSB first, then one high stop bit. Every bit lasts one `baud_tick` period, and transitions occur only on the clock edge that samples `baud_tick`=1.
- R6: `buf_empty` rises when the buffered byte moves into the shift engine. A byte written at that point is sent directly after the current stop bit, with no idle bit between.
- R7: A break requested while a character is shifting waits until that character's stop bit completes. A pending break is sent before a pending buffered byte.
- R8: A header written as break strobe, then 0x55, then an identifier byte on `buf_empty` appears on the line as break, delimiter, 0x55 and identifier, in that order.
- R9: `tx_done` is 1 exactly when the shift engine is idle, the buffer is empty and no break is pending. Whenever `tx_done` is 1, `txd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| master_mode | input | 1 | 1 = bus master (break allowed), 0 = slave |
| brk_wr | input | 1 | One-cycle break request strobe |
| data_wr | input | 1 | One-cycle write strobe for the holding buffer |
| data_in | input | 8 | Byte to transmit |
| txd | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Holding buffer can take a byte |
| tx_done | output | 1 | Nothing in flight or pending |

## Verification
The functions that can meet on the same clock edge are break scheduling and buffer unloading. When a character's stop bit ends with both a break request and a buffered byte waiting, a single tick must choose between them. The bench provokes this by loading one byte, queuing a second, and striking the break strobe mid-character. It then decodes the line and judges the order character, break, character, together with the 13-bit break length and the one-bit delimiter.

// File: rtl/lin_hdr_tx_pkg.sv
// Shared types for the LIN header transmitter.
package lin_hdr_tx_pkg;

    // Shift engine line states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BRK   = 2'd1,
        ST_DELIM = 2'd2,
        ST_CHAR  = 2'd3
    } tx_state_t;

endpackage

// File: rtl/lin_tx_hold.sv
// Holding buffer: one byte waiting for the shift engine.
// Assumes software writes only when empty. A write on the same edge as an
// unload is kept, and the shift engine takes the old byte.
module lin_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              unload,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Track occupancy and capture written bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            full <= (full & ~unload) | wr;
            if (wr) begin
                data <= wdata;
            end
        end
    end

    AST_EMPTY_ON_UNLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (unload && !wr) |=> !full); // R6

endmodule

// File: rtl/lin_tx_brkreq.sv
// Break request latch.
// A strobe is accepted only in master mode. The latch clears when the shift
// engine starts the break field.
module lin_tx_brkreq (
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic brk_wr,
    input  logic take,
    output logic pend
);

    // Hold a master break request until it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            pend <= (pend & ~take) | (brk_wr & master_mode);
        end
    end

    AST_SLAVE_NO_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_wr && !master_mode && !pend) |=> !pend); // R3

endmodule

// File: rtl/lin_tx_shift.sv
// Shift engine: sends a break field plus delimiter, or one framed character.
// Assumes baud_tick is a single-cycle pulse. All line changes happen on tick
// edges. At each frame boundary a pending break wins over a buffered byte.
module lin_tx_shift
    import lin_hdr_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BRK_BITS   = 13,
    parameter int DELIM_BITS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              brk_pend,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    output logic              brk_take,
    output logic              load,
    output logic              txd,
    output logic              idle
);

    localparam int CHAR_BITS = DATA_W + 2;
    localparam int MAX_BITS  = (BRK_BITS > CHAR_BITS) ? BRK_BITS : CHAR_BITS;
    localparam int CW        = $clog2(MAX_BITS + 1);
    localparam logic [CW-1:0] BRK_LAST   = CW'(BRK_BITS - 1);
    localparam logic [CW-1:0] DELIM_LAST = CW'(DELIM_BITS - 1);
    localparam logic [CW-1:0] CHAR_LAST  = CW'(CHAR_BITS - 1);

    tx_state_t       state;
    logic [CW-1:0]   cnt;
    logic [DATA_W:0] sreg;
    logic            boundary;

    // Find the tick that ends the current field, or a tick while idle.
    always_comb begin
        boundary = 1'b0;
        if (baud_tick) begin
            case (state)
                ST_IDLE:  boundary = 1'b1;
                ST_DELIM: boundary = (cnt == DELIM_LAST);
                ST_CHAR:  boundary = (cnt == CHAR_LAST);
                default:  boundary = 1'b0;
            endcase
        end
        brk_take = boundary & brk_pend;
        load     = boundary & ~brk_pend & buf_full;
    end

    // Advance the line one bit per tick and start the next field at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sreg  <= '1;
            txd   <= 1'b1;
        end else if (boundary) begin
            cnt <= '0;
            if (brk_pend) begin
                state <= ST_BRK;
                txd   <= 1'b0;
            end else if (buf_full) begin
                state <= ST_CHAR;
                sreg  <= {1'b1, buf_data};
                txd   <= 1'b0;
            end else begin
                state <= ST_IDLE;
                txd   <= 1'b1;
            end
        end else if (baud_tick) begin
            case (state)
                ST_BRK: begin
                    if (cnt == BRK_LAST) begin
                        state <= ST_DELIM;
                        cnt   <= '0;
                        txd   <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DELIM: begin
                    cnt <= cnt + 1'b1;
                end
                ST_CHAR: begin
                    txd  <= sreg[0];
                    sreg <= {1'b1, sreg[DATA_W:1]};
                    cnt  <= cnt + 1'b1;
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    assign idle = (state == ST_IDLE);

    AST_BREAK_WAITS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHAR && !(baud_tick && cnt == CHAR_LAST)) |=> (state == ST_CHAR)); // R7

    AST_BREAK_TO_DELIM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRK && baud_tick && cnt == BRK_LAST) |=> (state == ST_DELIM && txd)); // R4

endmodule

// File: rtl/lin_hdr_tx.sv
// LIN header transmitter top: holding buffer, break latch and shift engine.
// Assumes an external generator supplies baud_tick once per bit period.
module lin_hdr_tx #(
    parameter int DATA_W     = 8,
    parameter int BRK_BITS   = 13,
    parameter int DELIM_BITS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              master_mode,
    input  logic              brk_wr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_done
);

    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              brk_pend;
    logic              brk_take;
    logic              load;
    logic              eng_idle;
    logic              past_ok;

    lin_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (data_wr),
        .wdata  (data_in),
        .unload (load),
        .full   (buf_full),
        .data   (buf_data)
    );

    lin_tx_brkreq u_brk (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .brk_wr      (brk_wr),
        .take        (brk_take),
        .pend        (brk_pend)
    );

    lin_tx_shift #(
        .DATA_W     (DATA_W),
        .BRK_BITS   (BRK_BITS),
        .DELIM_BITS (DELIM_BITS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .brk_pend  (brk_pend),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .brk_take  (brk_take),
        .load      (load),
        .txd       (txd),
        .idle      (eng_idle)
    );

    assign buf_empty = ~buf_full;
    assign tx_done   = eng_idle & ~buf_full & ~brk_pend;

    // Mark the first cycle after reset, so that history checks are valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(baud_tick)) |-> $stable(txd)); // R5

    AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> txd); // R9

    AST_RESET_STATE: assert property (@(posedge clk)
        (!past_ok && rst_n) |-> (txd && buf_empty)); // R1

endmodule

// File: tb/lin_hdr_tx_bench.sv
// Scoreboard bench: tests push expected line items; a monitor decodes txd at each tick.
module lin_hdr_tx_bench;

    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       master_mode = 1'b1;
    logic       brk_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       txd;
    logic       buf_empty;
    logic       tx_done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tick_div = 0;

    typedef struct packed { logic brk; logic [7:0] d; } item_t;
    item_t exp_q[$];

    int       dstate = 0;
    int       nb = 0;
    logic [9:0] fr = '0;
    int       zrun = 0;
    int       hi_run = 0;
    bit       last_brk = 0;
    int       seen = 0;

    always #10 clk = ~clk;

    lin_hdr_tx u_lin_hdr_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .master_mode (master_mode),
        .brk_wr      (brk_wr),
        .data_wr     (data_wr),
        .data_in     (data_in),
        .txd         (txd),
        .buf_empty   (buf_empty),
        .tx_done     (tx_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic exp_push(input bit b, input logic [7:0] d);
        exp_q.push_back('{brk: b, d: d});
    endtask

    // Compare one decoded line item against the scoreboard.
    task automatic emit(input bit b, input logic [7:0] d, input int len);
        item_t e;
        seen++;
        if (exp_q.size() == 0) begin
            chk(0, b ? "R3 unexpected break" : "R3 unexpected char", int'(d), -1);
            return;
        end
        e = exp_q.pop_front();
        chk(e.brk == b, "R7 item kind/order", int'(b), int'(e.brk));
        if (b && e.brk) chk(len == 13, "R2 break length", len, 13);
        if (!b && !e.brk) chk(d == e.d, "R5 char data", int'(d), int'(e.d));
    endtask

    // Tick generator and line monitor, one ordered process at the falling edge.
    always @(negedge clk) begin
        if (rst_n && baud_tick) begin
            case (dstate)
                0: begin
                    if (txd == 1'b0) begin
                        if (last_brk) chk(hi_run == 1, "R4 delimiter length", hi_run, 1);
                        last_brk = 0;
                        dstate = 1; fr = '0; nb = 1;
                    end else begin
                        hi_run++;
                    end
                end
                1: begin
                    fr[nb] = txd; nb++;
                    if (nb == 10) begin
                        if (txd) begin
                            emit(0, fr[8:1], 0);
                            dstate = 0; hi_run = 0;
                        end else begin
                            zrun = 10; dstate = 2;
                        end
                    end
                end
                default: begin
                    if (txd == 1'b0) zrun++;
                    else begin
                        emit(1, 8'h00, zrun);
                        dstate = 0; hi_run = 1; last_brk = 1;
                    end
                end
            endcase
        end
        tick_div = (tick_div + 1) % DIV;
        baud_tick <= (tick_div == 0);
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(0, "watchdog", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); data_in = d; data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic pulse_brk();
        @(negedge clk); brk_wr = 1'b1;
        @(negedge clk); brk_wr = 1'b0;
    endtask

    task automatic wait_empty();
        @(negedge clk);
        while (!buf_empty) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_done || dstate != 0) @(negedge clk);
        repeat (3 * DIV) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset values, read while reset is held
        chk(txd == 1'b1, "R1 txd high", int'(txd), 1);
        chk(buf_empty == 1'b1, "R1 buffer empty", int'(buf_empty), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_done == 1'b1, "R1 done / no break pending", int'(tx_done), 1);

        // R8 header: break, synch 0x55 queued during break, identifier on empty
        master_mode = 1'b1;
        exp_push(1, 8'h00); exp_push(0, 8'h55); exp_push(0, 8'h3C);
        pulse_brk();
        write_byte(8'h55);
        chk(buf_empty == 1'b0, "R6 buffer holds synch", int'(buf_empty), 0);
        chk(tx_done == 1'b0, "R9 busy while pending", int'(tx_done), 0);
        wait_empty();
        chk(tx_done == 1'b0, "R6 empty while synch shifts", int'(tx_done), 0);
        write_byte(8'h3C);
        wait_idle();
        chk(exp_q.size() == 0, "R8 header complete", exp_q.size(), 0);
        chk(tx_done == 1'b1 && txd == 1'b1, "R9 done and idle high", int'(tx_done), 1);

        // R5 / R6 back-to-back characters with edge data patterns
        exp_push(0, 8'h00); exp_push(0, 8'hFF); exp_push(0, 8'hA3);
        write_byte(8'h00);
        wait_empty(); write_byte(8'hFF);
        wait_empty(); write_byte(8'hA3);
        wait_idle();
        chk(exp_q.size() == 0, "R5 chars decoded", exp_q.size(), 0);

        // R7 break strobed mid-character with a second byte already queued
        exp_push(0, 8'h81); exp_push(1, 8'h00); exp_push(0, 8'h42);
        write_byte(8'h81);
        wait_empty(); write_byte(8'h42);
        repeat (3 * DIV) @(negedge clk);
        pulse_brk();
        chk(txd == 1'b1 || txd == 1'b0, "R7 strobe accepted mid-char", 1, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R7 order char, break, char", exp_q.size(), 0);

        // R3 slave mode: break strobe ignored
        master_mode = 1'b0;
        begin
            int seen0;
            int lowcnt;
            seen0 = seen;
            lowcnt = 0;
            pulse_brk();
            for (int i = 0; i < 30 * DIV; i++) begin
                @(negedge clk);
                if (!txd || !tx_done) lowcnt++;
            end
            chk(lowcnt == 0, "R3 line high and done in slave", lowcnt, 0);
            chk(seen == seen0, "R3 no item in slave", seen - seen0, 0);
        end
        exp_push(0, 8'h5A);
        write_byte(8'h5A);
        wait_idle();
        chk(exp_q.size() == 0, "R3 chars still sent in slave", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule